// File: doc/BRIEF.md
# Push-button event filter

This block turns a raw, asynchronous mechanical switch input into a clean event in the system clock domain. The pin first passes through a chain of two flip-flops, so that no other logic sees an unsynchronized value. A stability counter then waits until the synchronized button has read as pressed for a full debounce interval. Reaching that count is taken as a valid press, and the terminal-count flag itself is the debounced level.

A one-cycle event pulse is formed from that debounced level by comparing it with a registered copy. A two-bit select input chooses whether the event marks the press, the release, or both. The debounce interval is a parameter derived from the clock rate and the bounce time in milliseconds. This allows windows of tens of milliseconds at any practical clock rate without changing the logic.

Top module: `btn_event_filter`

## Requirements
- R1: The raw pin is sampled by two back-to-back flops before any other logic uses it. With the raw input first sampled high at clock edge k and held, the debounced level rises at edge k+1+DEBOUNCE_CYCLES.
- R2: While the synchronized button reads low, the stability counter clears synchronously. Any low sample during a press therefore restarts the interval from zero.
- R3: The debounced level is high exactly while the counter sits at terminal count. It falls at the third clock edge after the raw input is first driven low.
- R4: The counter stops at terminal count, so a press held for any length of time yields exactly one press event.
- R5: The terminal count DEBOUNCE_CYCLES equals CLK_HZ*BOUNCE_MS/1000, and it must be at least 2. The counter is just wide enough to hold that value.
- R6: edge_sel = 2'b00 selects press events: a pulse in the first cycle in which the debounced level is high.
- R7: edge_sel = 2'b01 selects release events: a pulse in the first cycle in which the debounced level is low after being high.
- R8: edge_sel = 2'b10 selects both: one pulse on the press and one on the release.
- R9: edge_sel = 2'b11 is reserved and behaves exactly as 2'b00.
- R10: Every event pulse lasts exactly one clock cycle. A new event needs the debounced level to change again.
- R11: Asynchronous reset clears the synchronizer, counter and edge register. While reset is held, and in the cycles right after it, both outputs are low, even if the button is held down throughout.
- R12: A high burst on the raw input shorter than DEBOUNCE_CYCLES sampled edges produces no event, and the debounced level stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst | input | 1 | Asynchronous reset, active high |
| btn_raw | input | 1 | Raw button pin, high when pressed, asynchronous |
| edge_sel | input | 2 | Event polarity: 00 press, 01 release, 10 both, 11 as 00 |
| btn_level | output | 1 | Debounced button level |
| btn_event | output | 1 | One-cycle event pulse |

## Verification
Each of the four polarity codes is tried with two kinds of press: a clean step and a press wrapped in random chatter. In the chatter case, every high burst is shorter than the interval and every low gap is one to three cycles, both on the way in and on the way out. A clean step shows the exact latency through the synchronizer and the counter. Chatter shows whether low samples really restart the count, and whether release chatter can start a second press. A lone short burst, and a button held through reset, separate a filter that truly waits a full stable interval from one that reacts to any high sample or to leftover state.

// File: rtl/btn_event_pkg.sv
`timescale 1ns/1ps
package btn_event_pkg;

   typedef enum logic [1:0] {
      EDGE_PRESS   = 2'b00,
      EDGE_RELEASE = 2'b01,
      EDGE_BOTH    = 2'b10,
      EDGE_RSVD    = 2'b11
   } edge_sel_e;

   function automatic longint unsigned interval_cycles(longint unsigned clk_hz,
                                                       longint unsigned bounce_ms);
      return (clk_hz * bounce_ms) / 64'd1000;
   endfunction

endpackage

// File: rtl/btn_sync_chain.sv
`timescale 1ns/1ps
module btn_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) stage_q <= '0;
      else      stage_q <= {stage_q[STAGES-2:0], d_async};
   end

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/btn_stable_count.sv
`timescale 1ns/1ps
module btn_stable_count #(
   parameter longint unsigned LIMIT = 1000,
   parameter int              CNT_W = 10
) (
   input  logic clk,
   input  logic arst,
   input  logic pressed,
   output logic at_limit
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;

   assign at_limit = (cnt_q == LIM);

   always_ff @(posedge clk or posedge arst) begin
      if (arst)           cnt_q <= '0;
      else if (!pressed)  cnt_q <= '0;
      else if (!at_limit) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/btn_edge_pick.sv
`timescale 1ns/1ps
module btn_edge_pick
   import btn_event_pkg::*;
(
   input  logic       clk,
   input  logic       arst,
   input  logic       level,
   input  logic [1:0] sel,
   output logic       pulse
);
   logic level_d;
   logic went_up, went_down;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) level_d <= 1'b0;
      else      level_d <= level;
   end

   assign went_up   = level & ~level_d;
   assign went_down = ~level & level_d;

   always_comb begin
      case (edge_sel_e'(sel))
         EDGE_RELEASE: pulse = went_down;
         EDGE_BOTH:    pulse = went_up ^ went_down;
         default:      pulse = went_up;
      endcase
   end
endmodule

// File: rtl/btn_event_filter.sv
`timescale 1ns/1ps
module btn_event_filter
   import btn_event_pkg::*;
#(
   parameter longint unsigned CLK_HZ      = 50_000_000,
   parameter longint unsigned BOUNCE_MS   = 20,
   parameter int              SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       arst,
   input  logic       btn_raw,
   input  logic [1:0] edge_sel,
   output logic       btn_level,
   output logic       btn_event
);
   localparam longint unsigned DEBOUNCE_CYCLES = interval_cycles(CLK_HZ, BOUNCE_MS);
   localparam int              CNT_W           = $clog2(DEBOUNCE_CYCLES + 1);

   generate
      if (DEBOUNCE_CYCLES < 2) begin : g_bad_interval
         $error("btn_event_filter: debounce interval below 2 cycles");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("btn_event_filter: synchronizer needs at least 2 stages");
      end
   endgenerate

   logic btn_sync;

   btn_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .arst    (arst),
      .d_async (btn_raw),
      .q_sync  (btn_sync)
   );

   btn_stable_count #(.LIMIT(DEBOUNCE_CYCLES), .CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .arst     (arst),
      .pressed  (btn_sync),
      .at_limit (btn_level)
   );

   btn_edge_pick u_edge (
      .clk   (clk),
      .arst  (arst),
      .level (btn_level),
      .sel   (edge_sel),
      .pulse (btn_event)
   );
endmodule

// File: rtl/btn_event_filter_chk.sv
`timescale 1ns/1ps
module btn_event_filter_chk (
   input logic       clk,
   input logic       arst,
   input logic       btn_raw,
   input logic [1:0] edge_sel,
   input logic       btn_level,
   input logic       btn_event
);
   // R11: outputs quiet throughout reset
   always @(posedge clk) begin
      if (arst) begin
         a_r11_reset_quiet: assert (!btn_level && !btn_event)
            else $error("outputs active during reset");
      end
   end

   // R1: level can only rise if the pin was high three samples back
   a_r1_rise_needs_pin: assert property (@(posedge clk) disable iff (arst)
      $rose(btn_level) |-> $past(btn_raw, 3));

   // R2: a low pin sample clears the level via the counter
   a_r2_low_clears: assert property (@(posedge clk) disable iff (arst)
      !$past(btn_raw, 3) |-> !btn_level);

   // R4: terminal count holds while the pin stays high
   a_r4_saturates: assert property (@(posedge clk) disable iff (arst)
      ($past(btn_level) && $past(btn_raw, 3)) |-> btn_level);

   // R6 / R9: press events only with the level high
   a_r6_press_level: assert property (@(posedge clk) disable iff (arst)
      (btn_event && !edge_sel[0] && !edge_sel[1]) || (btn_event && (edge_sel == 2'b11))
      |-> btn_level);

   // R7: release events only with the level low
   a_r7_release_level: assert property (@(posedge clk) disable iff (arst)
      (btn_event && (edge_sel == 2'b01)) |-> !btn_level);

   // R10: an event always coincides with a level change
   a_r10_event_on_change: assert property (@(posedge clk) disable iff (arst)
      btn_event |-> (btn_level != $past(btn_level)));
endmodule

bind btn_event_filter btn_event_filter_chk u_chk (
   .clk       (clk),
   .arst      (arst),
   .btn_raw   (btn_raw),
   .edge_sel  (edge_sel),
   .btn_level (btn_level),
   .btn_event (btn_event)
);

// File: tb/btn_event_filter_bench.sv
`timescale 1ns/1ps
module btn_event_filter_bench;
   localparam longint unsigned CLK_HZ    = 1000;
   localparam longint unsigned BOUNCE_MS = 10;
   localparam int              N         = 10;   // CLK_HZ*BOUNCE_MS/1000 (R5)

   logic       clk      = 1'b0;
   logic       arst     = 1'b0;
   logic       btn_raw  = 1'b0;
   logic [1:0] edge_sel = 2'b00;
   wire        btn_level;
   wire        btn_event;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   int pulse_cyc[$];
   int width_err = 0;
   int level_hi = 0;
   bit prev_ev = 1'b0;

   btn_event_filter #(.CLK_HZ(CLK_HZ), .BOUNCE_MS(BOUNCE_MS)) u_btn_event_filter (
      .clk       (clk),
      .arst      (arst),
      .btn_raw   (btn_raw),
      .edge_sel  (edge_sel),
      .btn_level (btn_level),
      .btn_event (btn_event)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!arst) begin
         if (btn_event) begin
            pulse_cyc.push_back(cyc);
            if (prev_ev) width_err++;
         end
         if (btn_level) level_hi++;
         prev_ev = btn_event;
      end else begin
         prev_ev = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // hold btn_raw at v for n sampled edges; 'at' is the cycle it was applied
   task automatic put(input logic v, input int n, output int at);
      @(posedge clk);
      #1;
      btn_raw = v;
      at = cyc;
      repeat (n - 1) @(posedge clk);
   endtask

   task automatic run_mode(input logic [1:0] sel, input bit bouncy, input string req);
      int c, c_press, c_rel, base, wbase, np, exp_n;
      int exp_first;
      @(posedge clk);
      #1;
      edge_sel = sel;
      base  = pulse_cyc.size();
      wbase = width_err;
      if (bouncy) begin
         repeat (4) begin
            put(1'b1, $urandom_range(N - 1, 1), c);
            put(1'b0, $urandom_range(3, 1), c);
         end
      end
      put(1'b1, 3 * N, c_press);
      @(negedge clk);
      chk(btn_level == 1'b1, "R3", "level after stable press", btn_level, 1);
      if (bouncy) begin
         put(1'b0, $urandom_range(3, 1), c_rel);
         repeat (4) begin
            put(1'b1, $urandom_range(N - 1, 1), c);
            put(1'b0, $urandom_range(3, 1), c);
         end
         put(1'b0, 3 * N, c);
      end else begin
         put(1'b0, 3 * N, c_rel);
      end
      @(negedge clk);
      chk(btn_level == 1'b0, "R3", "level after release", btn_level, 0);
      np    = pulse_cyc.size() - base;
      exp_n = (sel == 2'b10) ? 2 : 1;
      chk(np == exp_n, req, "event count (R4 R2)", np, exp_n);
      exp_first = (sel == 2'b01) ? (c_rel + 3) : (c_press + N + 2);
      if (np >= 1)
         chk(pulse_cyc[base] == exp_first, req, "first event cycle (R1)", pulse_cyc[base], exp_first);
      if (sel == 2'b10 && np >= 2)
         chk(pulse_cyc[base + 1] == c_rel + 3, "R8", "release event cycle", pulse_cyc[base + 1], c_rel + 3);
      chk(width_err == wbase, "R10", "pulses wider than one cycle", width_err - wbase, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int c_r, c, base, lh;
      bit quiet;
      #1;
      arst    = 1'b1;
      btn_raw = 1'b1;               // button held through reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!btn_level && !btn_event, "R11", "outputs during reset", {btn_level, btn_event}, 0);
      @(posedge clk);
      #1;
      arst = 1'b0;
      c_r  = cyc;
      base = pulse_cyc.size();
      quiet = 1'b1;
      repeat (N) begin
         @(negedge clk);
         if (btn_level || btn_event) quiet = 1'b0;
      end
      chk(quiet, "R11", "quiet after reset release", !quiet, 0);
      repeat (2 * N) @(posedge clk);
      chk(pulse_cyc.size() - base == 1, "R11", "single event after reset", pulse_cyc.size() - base, 1);
      if (pulse_cyc.size() > base)
         chk(pulse_cyc[base] == c_r + N + 2, "R1", "event latency from reset", pulse_cyc[base], c_r + N + 2);
      put(1'b0, 3 * N, c);

      // sweep every select code, clean and with chatter
      for (int s = 0; s < 4; s++) begin
         string rq;
         rq = (s == 0) ? "R6" : (s == 1) ? "R7" : (s == 2) ? "R8" : "R9";
         run_mode(2'(s), 1'b0, rq);
         run_mode(2'(s), 1'b1, rq);
         run_mode(2'(s), 1'b1, rq);
      end

      // R12: short bursts alone never reach the level
      for (int len = 1; len < N; len++) begin
         edge_sel = 2'b10;
         base = pulse_cyc.size();
         lh   = level_hi;
         put(1'b1, len, c);
         put(1'b0, 2 * N, c);
         chk(pulse_cyc.size() == base, "R12", "events from short burst", pulse_cyc.size() - base, 0);
         chk(level_hi == lh, "R12", "level high cycles from short burst", level_hi - lh, 0);
      end

      // R2: burst of N-1, one low sample, burst of N-1: still no event
      base = pulse_cyc.size();
      put(1'b1, N - 1, c);
      put(1'b0, 1, c);
      put(1'b1, N - 1, c);
      put(1'b0, 2 * N, c);
      chk(pulse_cyc.size() == base, "R2", "events after one-sample dropout", pulse_cyc.size() - base, 0);

      // R4: long hold gives a single press event in press mode
      edge_sel = 2'b00;
      base = pulse_cyc.size();
      put(1'b1, 20 * N, c);
      chk(pulse_cyc.size() - base == 1, "R4", "events over long hold", pulse_cyc.size() - base, 1);
      put(1'b0, 3 * N, c);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule